// File: doc/BRIEF.md
# Receive Frame Page Writer

This block stores one incoming Ethernet frame into a 2 KB receive page of packet memory, using the controller's fixed page layout. A start pulse arrives together with the frame length, while the receive settings and the allocator's free-page offer are already on their inputs. If the frame is accepted, the block claims the page. It writes a little-endian status word, then a little-endian byte count, then the payload as it streams in. Short frames get zero padding. When the receive settings keep the CRC, the block appends a CRC-32. A two-byte trailer closes the page. The last step pushes the page number onto the receive queue and raises the receive interrupt.

The frame stream is a valid/ready byte interface. Payload bytes are consumed only in the payload phase, and all other phases write one byte per clock. The memory side is a plain write port whose address is the page number joined to an 11-bit byte offset. A frame that cannot be stored is refused by a one-cycle reject pulse. A refused frame causes no memory write and claims no page.

Top module: `rx_page_writer`

## Requirements
- R1: A start with `rx_enable` low or `soft_reset` high is refused. The refusal is a `reject` pulse in the following cycle, with no `page_take`, no memory write and no queue push.
- R2: The page size is data + 6, plus 4 more when `strip_crc` is low. Data is 64 when the length is under 64, otherwise the length rounded down to even. A start is refused as in R1 when this size is above 2048 or when `page_avail` is low. A size of exactly 2048 is accepted.
- R3: Offsets 2 and 3 hold the page size of R2, low byte first.
- R4: Offsets 0 and 1 hold a 16-bit status word, low byte first. Bit 11 is set when the length exceeds 1518, bit 12 is set when the length is odd, and all other bits are zero.
- R5: Payload bytes are written from offset 4 in arrival order. For a frame of 64 bytes or more with odd length, the final byte is not written there; it is held for the trailer.
- R6: A frame shorter than 64 bytes has all its bytes written, including an odd last byte, followed by zero bytes up to offset 67.
- R7: When `strip_crc` is low, four CRC bytes follow the data, least significant byte first. The CRC is CRC-32 with reflected polynomial 0xEDB88320, all-ones start value and inverted result. It covers every data byte, including the zero padding and a held odd last byte.
- R8: The final two bytes are the held odd byte then 0x60 for a frame of 64 bytes or more with odd length. For every other frame they are 0x00 then 0x40. The last one lands at offset size-1.
- R9: On acceptance `page_take` is high in the start cycle. All writes go to that page, exactly size of them. `q_push` and `rcv_int` pulse once, with `q_page` equal to the page, in the cycle of the final trailer write.
- R10: While `busy` is high, `start` is ignored, including in the cycle of the queue push.
- R11: After reset the block is idle: `busy`, `ram_we`, `in_ready`, `q_push` and `reject` are low.
- R12: A payload cycle with `in_valid` low writes nothing and does not advance the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Frame start pulse |
| frame_len | input | LEN_W | Frame length in bytes, valid with `start` |
| rx_enable | input | 1 | Receive enabled |
| soft_reset | input | 1 | Soft reset in effect |
| strip_crc | input | 1 | Do not store a CRC |
| page_avail | input | 1 | Allocator has a free page |
| page_num | input | PAGE_W | Free page offered by the allocator |
| page_take | output | 1 | Page claimed this cycle |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_ready | output | 1 | Block accepts a stream byte |
| ram_we | output | 1 | Memory write enable |
| ram_addr | output | PAGE_W+11 | Page number and byte offset |
| ram_wdata | output | 8 | Memory write data |
| busy | output | 1 | Frame in progress |
| reject | output | 1 | Frame refused |
| q_push | output | 1 | Push page onto receive queue |
| q_page | output | PAGE_W | Page number being pushed |
| rcv_int | output | 1 | Receive interrupt set |

## Verification
The completion of one frame and the arrival of the next start can fall in the same clock. This is the cycle in which the trailer's last byte is written and the page is pushed. The bench raises `start` with acceptable settings exactly when it sees `q_push` high, and once more in the middle of the payload. It then judges the result at the ports. There must be a single `page_take` for the frame, a byte image identical to the expected layout and a single push, and afterwards the block must be idle with no further writes. Odd-length frames at 63, 101 and 1519 bytes, and the 2048-byte boundary on both sides, cover the trailer and refusal corners.

// File: rtl/rx_page_writer.sv
module rx_page_writer #(
  parameter int PAGE_W     = 2,
  parameter int LEN_W      = 12,
  parameter int PAGE_BYTES = 2048
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   start,
  input  logic [LEN_W-1:0]                       frame_len,
  input  logic                                   rx_enable,
  input  logic                                   soft_reset,
  input  logic                                   strip_crc,
  input  logic                                   page_avail,
  input  logic [PAGE_W-1:0]                      page_num,
  output logic                                   page_take,
  input  logic                                   in_valid,
  input  logic [7:0]                             in_data,
  output logic                                   in_ready,
  output logic                                   ram_we,
  output logic [PAGE_W+$clog2(PAGE_BYTES)-1:0]   ram_addr,
  output logic [7:0]                             ram_wdata,
  output logic                                   busy,
  output logic                                   reject,
  output logic                                   q_push,
  output logic [PAGE_W-1:0]                      q_page,
  output logic                                   rcv_int
);
  localparam int OFF_W    = $clog2(PAGE_BYTES);
  localparam int CW       = LEN_W + 1;
  localparam int MIN_LEN  = 64;
  localparam int LONG_LEN = 1518;
  localparam logic [31:0] POLY = 32'hEDB88320;

  typedef enum logic [2:0] {S_IDLE, S_HDR, S_DATA, S_PAD, S_CRC, S_TRL} st_t;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'h0, b};
    for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ POLY) : (r >> 1);
    return r;
  endfunction

  st_t               st;
  logic [1:0]        sub;
  logic [OFF_W-1:0]  off;
  logic [LEN_W-1:0]  cnt, len_r;
  logic              keep_r, short_r, odd_tail;
  logic [31:0]       hdr_r, crc;
  logic [7:0]        hold;
  logic [PAGE_W-1:0] page_r;

  wire              short_in = frame_len < LEN_W'(MIN_LEN);
  wire [CW-1:0]     data_len = short_in ? CW'(MIN_LEN) : CW'({frame_len[LEN_W-1:1], 1'b0});
  wire [CW-1:0]     total    = data_len + CW'(strip_crc ? 6 : 10);
  wire              ok       = rx_enable & ~soft_reset & page_avail & (total <= CW'(PAGE_BYTES));
  wire [15:0]       status   = {3'b000, frame_len[0], frame_len > LEN_W'(LONG_LEN), 11'h000};
  wire              last_in  = cnt == len_r - LEN_W'(1);
  wire              take     = (st == S_DATA) & in_valid;
  wire              skip_wr  = odd_tail & last_in;
  wire [7:0]        crc_byte = (st == S_DATA) ? in_data : 8'h00;

  assign page_take = (st == S_IDLE) & start & ok;
  assign in_ready  = st == S_DATA;
  assign busy      = st != S_IDLE;
  assign ram_addr  = {page_r, off};
  assign q_push    = (st == S_TRL) & (sub == 2'd1);
  assign rcv_int   = q_push;
  assign q_page    = page_r;
  assign ram_we    = (st == S_HDR) | (st == S_PAD) | (st == S_CRC) | (st == S_TRL) | (take & ~skip_wr);

  always_comb begin
    case (st)
      S_HDR:   ram_wdata = hdr_r[{sub, 3'b000} +: 8];
      S_DATA:  ram_wdata = in_data;
      S_CRC:   ram_wdata = ~crc[7:0];
      S_TRL:   ram_wdata = (sub == 2'd0) ? (odd_tail ? hold : 8'h00) : (odd_tail ? 8'h60 : 8'h40);
      default: ram_wdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; sub <= '0; off <= '0; cnt <= '0; len_r <= '0;
      keep_r <= 1'b0; short_r <= 1'b0; odd_tail <= 1'b0; hdr_r <= '0;
      crc <= '1; hold <= '0; page_r <= '0; reject <= 1'b0;
    end else begin
      reject <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          if (ok) begin
            st <= S_HDR; sub <= '0; off <= '0; cnt <= '0; crc <= '1;
            len_r <= frame_len; keep_r <= ~strip_crc; short_r <= short_in;
            odd_tail <= ~short_in & frame_len[0];
            hdr_r <= {16'(total), status}; page_r <= page_num;
          end else reject <= 1'b1;
        end
        S_HDR: begin
          off <= off + 1'b1; sub <= sub + 1'b1;
          if (sub == 2'd3) st <= (len_r == '0) ? S_PAD : S_DATA;
        end
        S_DATA: if (in_valid) begin
          cnt <= cnt + 1'b1;
          crc <= crc_step(crc, crc_byte);
          if (skip_wr) hold <= in_data;
          else off <= off + 1'b1;
          if (last_in) st <= short_r ? S_PAD : (keep_r ? S_CRC : S_TRL);
        end
        S_PAD: begin
          off <= off + 1'b1; cnt <= cnt + 1'b1;
          crc <= crc_step(crc, crc_byte);
          if (cnt == LEN_W'(MIN_LEN - 1)) st <= keep_r ? S_CRC : S_TRL;
        end
        S_CRC: begin
          off <= off + 1'b1; sub <= sub + 1'b1;
          crc <= {8'hFF, crc[31:8]};
          if (sub == 2'd3) st <= S_TRL;
        end
        S_TRL: begin
          off <= off + 1'b1; sub <= sub + 1'b1;
          if (sub == 2'd1) begin st <= S_IDLE; sub <= '0; end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rx_page_writer_chk.sv
module rx_page_writer_chk #(
  parameter int PAGE_W = 2,
  parameter int OFF_W  = 11
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    start,
  input logic                    page_take,
  input logic                    in_ready,
  input logic                    ram_we,
  input logic [PAGE_W+OFF_W-1:0] ram_addr,
  input logic [7:0]              ram_wdata,
  input logic                    busy,
  input logic                    reject,
  input logic                    q_push
);
  // R11: an idle block drives no write, no stream ready and no push
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ram_we && !in_ready && !q_push));

  // R2: a refusal never coincides with a push or a frame in progress
  p_reject_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reject |-> (!q_push && !busy));

  // R9: claiming a page starts a frame
  p_take_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    page_take |=> busy);

  // R9: the push ends the frame
  p_push_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    q_push |=> !busy);

  // R9: the page field of the address does not move during a frame
  p_page_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(ram_addr[PAGE_W+OFF_W-1:OFF_W]));

  // R8: the push cycle writes the trailer control byte
  p_push_ctrl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    q_push |-> (ram_we && (ram_wdata == 8'h40 || ram_wdata == 8'h60)));

  // R10: no page is claimed while a frame is in progress
  p_busy_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |-> !page_take);
endmodule

bind rx_page_writer rx_page_writer_chk #(.PAGE_W(PAGE_W), .OFF_W($clog2(PAGE_BYTES))) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .page_take(page_take), .in_ready(in_ready),
  .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata), .busy(busy),
  .reject(reject), .q_push(q_push)
);

// File: tb/rx_page_writer_test.sv
module rx_page_writer_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0, start = 1'b0;
  logic [11:0] frame_len = '0;
  logic        rx_enable = 1'b0, soft_reset = 1'b0, strip_crc = 1'b0, page_avail = 1'b0;
  logic [1:0]  page_num = '0;
  logic        page_take, in_valid, in_ready, ram_we, busy, reject, q_push, rcv_int;
  logic [7:0]  in_data, ram_wdata;
  logic [12:0] ram_addr;
  logic [1:0]  q_page;

  rx_page_writer uut (
    .clk(clk), .rst_n(rst_n), .start(start), .frame_len(frame_len), .rx_enable(rx_enable),
    .soft_reset(soft_reset), .strip_crc(strip_crc), .page_avail(page_avail), .page_num(page_num),
    .page_take(page_take), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata), .busy(busy), .reject(reject),
    .q_push(q_push), .q_page(q_page), .rcv_int(rcv_int)
  );

  int errors = 0, checks = 0, cyc = 0, sent = 0, nwr = 0;
  int n_take = 0, n_push = 0, n_rej = 0, n_int = 0;
  logic [7:0] img [0:2047];
  logic [1:0] wpage = '0, push_page = '0;
  bit page_bad = 0, gap = 0;
  logic [7:0] seed = '0;

  assign in_valid = gap ? cyc[0] : 1'b1;
  assign in_data  = 8'(sent * 7) + seed;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (in_valid && in_ready) sent <= sent + 1;
    if (ram_we) begin
      img[ram_addr[10:0]] <= ram_wdata;
      nwr <= nwr + 1;
      if (ram_addr[12:11] != wpage) page_bad <= 1;
    end
    if (page_take) n_take <= n_take + 1;
    if (reject) n_rej <= n_rej + 1;
    if (rcv_int) n_int <= n_int + 1;
    if (q_push) begin n_push <= n_push + 1; push_page <= q_page; end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  always @(posedge clk) if (cyc > 150000) begin
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
    summary();
    $finish;
  end

  function automatic logic [31:0] crc_upd(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r = c;
    for (int k = 0; k < 8; k++) begin
      if ((r[0] ^ b[k]) == 1'b1) r = (r >> 1) ^ 32'hEDB88320;
      else r = r >> 1;
    end
    return r;
  endfunction

  task automatic run(input int len, input bit strip, input bit en, input bit srst, input bit avail,
                     input bit gp, input bit exp_rej, input logic [1:0] pg, input bit poke);
    logic [7:0] e [0:2047];
    logic [7:0] d [0:2047];
    int tot, dn, p, bad, it;
    bit shrt;
    logic [31:0] c;
    logic [15:0] st;
    @(negedge clk);
    for (int k = 0; k < 2048; k++) img[k] = 8'hEE;
    nwr = 0; n_take = 0; n_push = 0; n_rej = 0; n_int = 0; sent = 0; page_bad = 0;
    wpage = pg; gap = gp; seed = 8'(len) ^ 8'h5A;
    frame_len = 12'(len); strip_crc = strip; rx_enable = en; soft_reset = srst;
    page_avail = avail; page_num = pg; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    it = 0;
    while (n_push == 0 && n_rej == 0 && it < 6000) begin
      start = poke && (q_push || it == 10);
      @(negedge clk);
      it++;
    end
    start = 1'b0;
    repeat (3) @(negedge clk);
    if (exp_rej) begin
      chk(n_rej == 1 && n_take == 0 && nwr == 0 && n_push == 0,
          (!en || srst) ? "R1 refusal" : "R2 refusal", nwr + 100 * n_take + 1000 * n_rej, 1000);
      return;
    end
    shrt = len < 64;
    dn   = shrt ? 64 : (len & ~1);
    tot  = dn + (strip ? 6 : 10);
    st   = 16'((len > 1518 ? 16'h0800 : 16'h0) | ((len & 1) != 0 ? 16'h1000 : 16'h0));
    for (int k = 0; k < 2048; k++) d[k] = (k < len) ? (8'(k * 7) + seed) : 8'h00;
    c = 32'hFFFFFFFF;
    for (int k = 0; k < (shrt ? 64 : len); k++) c = crc_upd(c, d[k]);
    c = ~c;
    e[0] = st[7:0]; e[1] = st[15:8]; e[2] = 8'(tot); e[3] = 8'(tot >> 8);
    p = 4;
    for (int k = 0; k < dn; k++) begin e[p] = d[k]; p++; end
    if (!strip) for (int k = 0; k < 4; k++) begin e[p] = 8'(c >> (8 * k)); p++; end
    if (!shrt && (len & 1) != 0) begin e[p] = d[len - 1]; e[p + 1] = 8'h60; end
    else begin e[p] = 8'h00; e[p + 1] = 8'h40; end
    chk({img[1], img[0]} == st, "R4 status", {img[1], img[0]}, st);
    chk({img[3], img[2]} == 16'(tot), "R3 count", {img[3], img[2]}, tot);
    bad = 0;
    for (int k = 4; k < 4 + dn; k++) if (img[k] !== e[k]) bad++;
    chk(bad == 0, shrt ? "R6 data and padding" : "R5 payload", bad, 0);
    if (!strip) chk({img[4+dn+3], img[4+dn+2], img[4+dn+1], img[4+dn]} == c, "R7 crc",
                    {img[4+dn+3], img[4+dn+2], img[4+dn+1], img[4+dn]}, c);
    chk(img[tot-2] === e[tot-2] && img[tot-1] === e[tot-1], "R8 trailer",
        {img[tot-2], img[tot-1]}, {e[tot-2], e[tot-1]});
    chk(nwr == tot && !page_bad, "R9 write count and page", nwr, tot);
    chk(n_take == 1 && n_push == 1 && n_int == 1 && push_page == pg, "R9 push",
        100 * n_take + 10 * n_push + push_page, 110 + pg);
    if (poke) chk(!busy && n_take == 1, "R10 start while busy", n_take + 10 * busy, 1);
  endtask

  // len, strip, en, srst, avail, gap, reject, page
  localparam bit [19:0] VEC [15] = '{
    {12'd100,  1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 2'd1},
    {12'd101,  1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 2'd2},
    {12'd40,   1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0},
    {12'd41,   1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 2'd3},
    {12'd1600, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 2'd2},
    {12'd2044, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 2'd0},
    {12'd2042, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 2'd1},
    {12'd2038, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 2'd3},
    {12'd2040, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 2'd0},
    {12'd100,  1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 2'd0},
    {12'd100,  1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 2'd0},
    {12'd100,  1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0},
    {12'd64,   1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0},
    {12'd63,   1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 2'd1},
    {12'd1519, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 2'd2}
  };

  initial begin
    logic [31:0] cc;
    repeat (3) @(negedge clk);
    chk(!busy && !ram_we && !in_ready && !q_push && !reject, "R11 reset state",
        {busy, ram_we, in_ready, q_push, reject}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !ram_we && !in_ready, "R11 idle after reset", {busy, ram_we, in_ready}, 0);
    cc = 32'hFFFFFFFF;
    for (int k = 0; k < 9; k++) cc = crc_upd(cc, 8'h31 + 8'(k));
    chk(~cc == 32'hCBF43926, "R7 crc reference", ~cc, 32'hCBF43926);
    foreach (VEC[i])
      run(int'(VEC[i][19:8]), VEC[i][7], VEC[i][6], VEC[i][5], VEC[i][4], VEC[i][3],
          VEC[i][2], VEC[i][1:0], 1'b0);
    // R10: start raised mid-payload and in the push cycle
    run(80, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 2'd3, 1'b1);
    // R12: a stalled stream writes nothing during the gap
    @(negedge clk);
    nwr = 0; sent = 0; gap = 1'b0; seed = 8'h00;
    frame_len = 12'd70; strip_crc = 1'b1; rx_enable = 1'b1; soft_reset = 1'b0;
    page_avail = 1'b1; page_num = 2'd0; wpage = 2'd0; start = 1'b1;
    force in_valid = 1'b0;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    chk(nwr == 4 && sent == 0 && in_ready, "R12 stall", nwr + 100 * sent, 4);
    release in_valid;
    repeat (90) @(negedge clk);
    chk(!busy && nwr == 76, "R12 resume", nwr, 76);
    summary();
    $finish;
  end
endmodule